// File: doc/BRIEF.md
# Per-Access-Kind One-Entry Address Translation Cache

This block sits in front of a page table walker. It holds three independent one-entry translation caches: one for instruction fetches, one for data reads and one for data writes. Each entry remembers one page of any of four sizes: the virtual page tag, the physical page base and that page's own size mask. A lookup is answered in the same cycle. On a hit the physical address is the stored base with the page offset taken from the virtual address. On a miss the request goes on to the walker and the permission checker.

When the walker finishes, it presents the result on the fill port. The result carries the page size, the domain access type and the outcome of the permission check. The entry of that access kind is rewritten only when the access was allowed through a manager domain, or through a client domain whose permission check passed. When translation is switched off, every lookup passes straight through. A flush input empties all three entries at once.

Each entry is a two-state machine. `ENT_EMPTY` goes to `ENT_LIVE` on a committed fill (transition "load"). `ENT_LIVE` stays in `ENT_LIVE` on a later committed fill (transition "replace"). Both states go to `ENT_EMPTY` on flush or reset (transition "drop"). Flush has priority over a fill in the same cycle.

Top module: `xlat_tri_buffer`

## Requirements
- R1: After reset, all three entries are empty: with translation enabled, a lookup of any kind reports a miss.
- R2: A committed fill stores tag = vaddr & mask, base = paddr & mask and the mask. A later lookup of that kind whose masked vaddr equals the tag hits, with paddr = base | (vaddr & ~mask).
- R3: A lookup whose masked vaddr differs from the stored tag misses.
- R4: The fill size code selects the page mask: 0 = 1 MB (offset bits [19:0]), 1 = 64 KB ([15:0]), 2 = 4 KB ([11:0]), 3 = 1 KB ([9:0]).
- R5: The kind codes are 0 = fetch, 1 = read and 2 = write. Each kind has its own entry, and a fill of one kind never changes the other entries. Code 3 never hits and never fills.
- R6: The domain codes are 0 = no access, 1 = client, 2 = reserved and 3 = manager. A fill commits only for manager, or for client with the permission-ok input high. Codes 0 and 2, and client without permission, leave the entry unchanged.
- R7: With translation disabled, a valid lookup reports a hit and no miss, and paddr equals the (aligned) vaddr.
- R8: Fetch lookups force vaddr bits [1:0] to zero before both comparison and output.
- R9: Flush empties all three entries in one cycle and overrides a committed fill in the same cycle.
- R10: Lookups are combinational in the current cycle. A fill becomes visible from the cycle after its clock edge, so a lookup in the fill cycle sees the old contents.
- R11: A committed fill replaces the previous page of that entry, which then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation enable; low means bypass |
| flush | input | 1 | Empty all entries |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 2 | Lookup access kind |
| lk_vaddr | input | AW | Lookup virtual address |
| lk_hit | output | 1 | Lookup answered |
| lk_miss | output | 1 | Lookup must go to the walker |
| lk_paddr | output | AW | Translated address, zero on miss |
| fill_valid | input | 1 | Walker result present |
| fill_kind | input | 2 | Access kind of the result |
| fill_vaddr | input | AW | Virtual address walked |
| fill_paddr | input | AW | Physical address found |
| fill_size | input | 2 | Page size code |
| fill_dom | input | 2 | Domain access type code |
| fill_perm_ok | input | 1 | Client permission check passed |

## Verification
Flush and a committed fill can land on the same clock edge. The bench raises flush in the same cycle as a manager-domain fetch fill, then looks up the filled page and expects a miss, because the flush wins. A lookup and a fill of the same kind can also share a cycle. That case is provoked by holding a read lookup of the page being filled: it must miss in that cycle and hit in the next one.

// File: rtl/xlat_tri_pkg.sv
package xlat_tri_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        DOM_NOACC    = 2'd0,
        DOM_CLIENT   = 2'd1,
        DOM_RESERVED = 2'd2,
        DOM_MANAGER  = 2'd3
    } dom_kind_t;

    typedef enum logic [1:0] {
        SZ_1M  = 2'd0,
        SZ_64K = 2'd1,
        SZ_4K  = 2'd2,
        SZ_1K  = 2'd3
    } page_size_t;

    typedef enum logic {
        ENT_EMPTY = 1'b0,
        ENT_LIVE  = 1'b1
    } ent_state_t;

    localparam int OFF_1M  = 20;
    localparam int OFF_64K = 16;
    localparam int OFF_4K  = 12;
    localparam int OFF_1K  = 10;
    localparam int FETCH_ALIGN = 2;

endpackage

// File: rtl/xlat_mask_gen.sv
module xlat_mask_gen
    import xlat_tri_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [1:0]    size_code,
    output logic [AW-1:0] mask
);
    localparam logic [AW-1:0] ONES = {AW{1'b1}};

    page_size_t sz;
    assign sz = page_size_t'(size_code);

    always_comb begin
        unique case (sz)
            SZ_1M:   mask = ONES << OFF_1M;
            SZ_64K:  mask = ONES << OFF_64K;
            SZ_4K:   mask = ONES << OFF_4K;
            SZ_1K:   mask = ONES << OFF_1K;
            default: mask = ONES << OFF_1K;
        endcase
    end

    always_comb begin
        assert_mask_shape_R4: assert (mask[AW-1] && mask[OFF_1M] && !mask[OFF_1K-1]);
    end
endmodule

// File: rtl/xlat_fill_gate.sv
module xlat_fill_gate
    import xlat_tri_pkg::*;
#(
    parameter int NK = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_valid,
    input  logic [1:0]    fill_kind,
    input  logic [1:0]    fill_dom,
    input  logic          fill_perm_ok,
    output logic [NK-1:0] commit
);
    dom_kind_t dom;
    logic      allowed;

    assign dom = dom_kind_t'(fill_dom);

    always_comb begin
        unique case (dom)
            DOM_NOACC:    allowed = 1'b0;
            DOM_CLIENT:   allowed = fill_perm_ok;
            DOM_RESERVED: allowed = 1'b0;
            DOM_MANAGER:  allowed = 1'b1;
            default:      allowed = 1'b0;
        endcase
    end

    always_comb begin
        commit = '0;
        for (int k = 0; k < NK; k++) begin
            if (fill_valid && allowed && (int'(fill_kind) == k))
                commit[k] = 1'b1;
        end
    end

    assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit));
    assert_denied_domain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_dom == 2'd0 || fill_dom == 2'd2) |-> (commit == '0));
endmodule

// File: rtl/xlat_entry.sv
module xlat_entry
    import xlat_tri_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_vaddr,
    input  logic [AW-1:0] wr_paddr,
    input  logic [AW-1:0] wr_mask,
    input  logic [AW-1:0] rd_vaddr,
    output logic          hit,
    output logic [AW-1:0] paddr
);
    ent_state_t    state_q, state_d;
    logic [AW-1:0] tag_q, base_q, mask_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_EMPTY: if (!flush && wr_en) state_d = ENT_LIVE;
            ENT_LIVE:  if (flush)           state_d = ENT_EMPTY;
            default:                        state_d = ENT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            base_q <= '0;
            mask_q <= '0;
        end else if (wr_en && !flush) begin
            tag_q  <= wr_vaddr & wr_mask;
            base_q <= wr_paddr & wr_mask;
            mask_q <= wr_mask;
        end
    end

    always_comb begin
        hit   = 1'b0;
        paddr = '0;
        unique case (state_q)
            ENT_EMPTY: ;
            ENT_LIVE: begin
                if ((rd_vaddr & mask_q) == tag_q) begin
                    hit   = 1'b1;
                    paddr = base_q | (rd_vaddr & ~mask_q);
                end
            end
            default: ;
        endcase
    end

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state_q == ENT_EMPTY));
    assert_fill_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (state_q == ENT_LIVE) && (tag_q == ($past(wr_vaddr) & $past(wr_mask))));
    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !flush) |=> ($stable(tag_q) && $stable(base_q) && $stable(state_q)));
endmodule

// File: rtl/xlat_tri_buffer.sv
module xlat_tri_buffer
    import xlat_tri_pkg::*;
#(
    parameter int AW = 32,
    parameter int NK = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mmu_en,
    input  logic          flush,
    input  logic          lk_valid,
    input  logic [1:0]    lk_kind,
    input  logic [AW-1:0] lk_vaddr,
    output logic          lk_hit,
    output logic          lk_miss,
    output logic [AW-1:0] lk_paddr,
    input  logic          fill_valid,
    input  logic [1:0]    fill_kind,
    input  logic [AW-1:0] fill_vaddr,
    input  logic [AW-1:0] fill_paddr,
    input  logic [1:0]    fill_size,
    input  logic [1:0]    fill_dom,
    input  logic          fill_perm_ok
);
    localparam logic [AW-1:0] ALIGN_MASK = {AW{1'b1}} << FETCH_ALIGN;

    logic [AW-1:0] fill_mask;
    logic [NK-1:0] commit;
    logic [AW-1:0] look_addr;
    logic [NK-1:0] ent_hit;
    logic [AW-1:0] ent_pa [NK];
    logic          sel_hit;
    logic [AW-1:0] sel_pa;

    assign look_addr = (acc_kind_t'(lk_kind) == KIND_FETCH) ? (lk_vaddr & ALIGN_MASK) : lk_vaddr;

    xlat_mask_gen #(.AW(AW)) u_mask (
        .size_code (fill_size),
        .mask      (fill_mask)
    );

    xlat_fill_gate #(.NK(NK)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid   (fill_valid),
        .fill_kind    (fill_kind),
        .fill_dom     (fill_dom),
        .fill_perm_ok (fill_perm_ok),
        .commit       (commit)
    );

    for (genvar k = 0; k < NK; k++) begin : g_ent
        xlat_entry #(.AW(AW)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .wr_en    (commit[k]),
            .wr_vaddr (fill_vaddr),
            .wr_paddr (fill_paddr),
            .wr_mask  (fill_mask),
            .rd_vaddr (look_addr),
            .hit      (ent_hit[k]),
            .paddr    (ent_pa[k])
        );
    end

    always_comb begin
        sel_hit = 1'b0;
        sel_pa  = '0;
        for (int k = 0; k < NK; k++) begin
            if (int'(lk_kind) == k) begin
                sel_hit = ent_hit[k];
                sel_pa  = ent_pa[k];
            end
        end
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_miss  = 1'b0;
        lk_paddr = '0;
        if (lk_valid) begin
            if (!mmu_en) begin
                lk_hit   = 1'b1;
                lk_paddr = look_addr;
            end else if (sel_hit) begin
                lk_hit   = 1'b1;
                lk_paddr = sel_pa;
            end else begin
                lk_miss  = 1'b1;
            end
        end
    end

    assert_hit_miss_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));
    assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !mmu_en) |-> (lk_hit && lk_paddr[AW-1:FETCH_ALIGN] == lk_vaddr[AW-1:FETCH_ALIGN]));
    assert_fetch_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'd0) |-> (lk_paddr[FETCH_ALIGN-1:0] == '0));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));
endmodule

// File: tb/sim_xlat_tri_buffer.sv
module sim_xlat_tri_buffer;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mmu_en = 1'b0, flush = 1'b0;
    logic          lk_valid = 1'b0;
    logic [1:0]    lk_kind = 2'd0;
    logic [AW-1:0] lk_vaddr = '0;
    logic          lk_hit, lk_miss;
    logic [AW-1:0] lk_paddr;
    logic          fill_valid = 1'b0;
    logic [1:0]    fill_kind = 2'd0, fill_size = 2'd0, fill_dom = 2'd0;
    logic [AW-1:0] fill_vaddr = '0, fill_paddr = '0;
    logic          fill_perm_ok = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_tri_buffer #(.AW(AW), .NK(3)) u0 (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .flush(flush),
        .lk_valid(lk_valid), .lk_kind(lk_kind), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .fill_valid(fill_valid), .fill_kind(fill_kind), .fill_vaddr(fill_vaddr),
        .fill_paddr(fill_paddr), .fill_size(fill_size), .fill_dom(fill_dom),
        .fill_perm_ok(fill_perm_ok)
    );

    // kind, vaddr, expected hit, expected paddr
    localparam logic [66:0] VEC [0:10] = '{
        {2'd1, 32'h123ABCDE, 1'b1, 32'hABCABCDE},
        {2'd1, 32'h124ABCDE, 1'b0, 32'h0},
        {2'd2, 32'h0002FFFF, 1'b1, 32'h7777FFFF},
        {2'd2, 32'h00030000, 1'b0, 32'h0},
        {2'd0, 32'h40001FFF, 1'b1, 32'h90005FFC},
        {2'd0, 32'h40002000, 1'b0, 32'h0},
        {2'd1, 32'h00023456, 1'b0, 32'h0},
        {2'd2, 32'h12345678, 1'b0, 32'h0},
        {2'd0, 32'h12345678, 1'b0, 32'h0},
        {2'd3, 32'h12345678, 1'b0, 32'h0},
        {2'd1, 32'h12300000, 1'b1, 32'hABC00000}
    };

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(input logic [1:0] k, input logic [AW-1:0] v, input bit eh,
                        input logic [AW-1:0] ep, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_kind = k; lk_vaddr = v;
        #1;
        chk(lk_hit == eh && lk_miss == !eh, req, {31'd0, lk_hit}, {31'd0, eh});
        if (eh) chk(lk_paddr == ep, req, lk_paddr, ep);
    endtask

    task automatic fill(input logic [1:0] k, input logic [AW-1:0] v, input logic [AW-1:0] p,
                        input logic [1:0] sz, input logic [1:0] d, input bit ok, input bit fl);
        @(negedge clk);
        fill_valid = 1'b1; fill_kind = k; fill_vaddr = v; fill_paddr = p;
        fill_size = sz; fill_dom = d; fill_perm_ok = ok; flush = fl;
        @(negedge clk);
        fill_valid = 1'b0; flush = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %h expected %h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mmu_en = 1'b1;
        // R1: empty after reset
        look(2'd0, 32'h40001000, 1'b0, 0, "R1 fetch");
        look(2'd1, 32'h12345678, 1'b0, 0, "R1 read");
        look(2'd2, 32'h00023456, 1'b0, 0, "R1 write");
        lk_valid = 1'b0;

        // R2 R4 R5 R6: one page per kind, different sizes and domains
        fill(2'd1, 32'h12345678, 32'hABC00000, 2'd0, 2'd3, 1'b0, 1'b0);
        fill(2'd2, 32'h00023456, 32'h77770000, 2'd1, 2'd1, 1'b1, 1'b0);
        fill(2'd0, 32'h40001000, 32'h90005000, 2'd2, 2'd3, 1'b0, 1'b0);
        fill(2'd3, 32'h12345678, 32'h11111111, 2'd0, 2'd3, 1'b0, 1'b0);

        // R2 R3 R4 R5 R8: vector table
        for (int i = 0; i < 11; i++) begin
            look(VEC[i][66:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], "R2/R3/R5 vector");
        end

        // R4 tiny page, R11 replaces the 1 MB read page
        fill(2'd1, 32'h55555755, 32'h00001C00, 2'd3, 2'd3, 1'b0, 1'b0);
        look(2'd1, 32'h555557FF, 1'b1, 32'h00001FFF, "R4 tiny hit");
        look(2'd1, 32'h55555800, 1'b0, 0, "R4 tiny edge");
        look(2'd1, 32'h12345678, 1'b0, 0, "R11 replaced");

        // R6: denied fills leave the write entry alone
        fill(2'd2, 32'h08000000, 32'h30000000, 2'd2, 2'd1, 1'b0, 1'b0);
        fill(2'd2, 32'h08000000, 32'h30000000, 2'd2, 2'd2, 1'b1, 1'b0);
        fill(2'd2, 32'h08000000, 32'h30000000, 2'd2, 2'd0, 1'b1, 1'b0);
        look(2'd2, 32'h08000000, 1'b0, 0, "R6 denied fill");
        look(2'd2, 32'h00020010, 1'b1, 32'h77770010, "R6 old page kept");
        fill(2'd2, 32'h08000000, 32'h30000000, 2'd2, 2'd1, 1'b1, 1'b0);
        look(2'd2, 32'h08000004, 1'b1, 32'h30000004, "R6 client ok");
        look(2'd2, 32'h00020010, 1'b0, 0, "R11 write replaced");

        // R10: lookup in the fill cycle sees old contents
        @(negedge clk);
        lk_valid = 1'b1; lk_kind = 2'd1; lk_vaddr = 32'h60000123;
        fill_valid = 1'b1; fill_kind = 2'd1; fill_vaddr = 32'h60000000; fill_paddr = 32'h0A000000;
        fill_size = 2'd2; fill_dom = 2'd3; fill_perm_ok = 1'b0;
        #1;
        chk(lk_miss && !lk_hit, "R10 same cycle", {31'd0, lk_hit}, 32'd0);
        @(negedge clk);
        fill_valid = 1'b0;
        #1;
        chk(lk_hit && lk_paddr == 32'h0A000123, "R10 next cycle", lk_paddr, 32'h0A000123);

        // R7 R8: bypass
        @(negedge clk);
        mmu_en = 1'b0; lk_kind = 2'd0; lk_vaddr = 32'hDEADBEEF;
        #1;
        chk(lk_hit && !lk_miss && lk_paddr == 32'hDEADBEEC, "R7/R8 bypass fetch", lk_paddr, 32'hDEADBEEC);
        lk_kind = 2'd1;
        #1;
        chk(lk_hit && !lk_miss && lk_paddr == 32'hDEADBEEF, "R7 bypass read", lk_paddr, 32'hDEADBEEF);
        mmu_en = 1'b1;

        // R9: flush with a same-cycle fill; flush wins, all empty
        fill(2'd0, 32'h70000000, 32'h20000000, 2'd0, 2'd3, 1'b0, 1'b1);
        look(2'd0, 32'h70000000, 1'b0, 0, "R9 flush beats fill");
        look(2'd1, 32'h60000123, 1'b0, 0, "R9 read flushed");
        look(2'd2, 32'h08000004, 1'b0, 0, "R9 write flushed");
        look(2'd1, 32'h555557FF, 1'b0, 0, "R9 read old");

        // R1: reset mid-run empties entries
        fill(2'd1, 32'h60000000, 32'h0A000000, 2'd2, 2'd3, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(2'd1, 32'h60000123, 1'b0, 0, "R1 reset clears");
        lk_valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule